// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register Bank

This block holds the control and status registers of a multi-channel DMA controller and merges the events of every channel into one interrupt line. The data movement engine reports three kinds of per-channel event: a transfer finished, the channel halted, or an address fault. Each event sets a sticky flag in that channel's status word, and where the event warrants an interrupt it also sets the channel's bit in a global pending word. Software reads these words over a plain 32-bit register bus. It clears them by writing zeros and then rings a doorbell to start the next descriptor fetch.

The global control word holds a master enable, a performance-mode bit and two summary flags. One summary flag records that some channel halted, and the other records that some channel hit an address fault. A programmable-channel mask is held for the fetch logic. Each channel also holds a descriptor base address, an enable bit and a descriptor-size select. All of these go straight out to the engine as plain level outputs. The doorbell produces a one-cycle fetch pulse per channel.

The bus has no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read returns its data on `bus_rdata` one clock after `bus_rd` is high, and that value is held until the next read. Event inputs are single-cycle strobes.

Top module: `dmairq_regs`

## Requirements
- R1: After reset every register reads zero and `irq_o`, `fetch_o`, `ch_en_o`, `ch_desc8_o`, `prog_o`, `perf_o`, `desc_addr_o` and `bus_rdata` are all zero.
- R2: Channel c's status word sits at byte address c*0x20+0x10. A write there sets its enable (bit 0, driven on `ch_en_o[c]`) and its eight-word-descriptor select (bit 30, driven on `ch_desc8_o[c]`) to the written bits.
- R3: A completion strobe on `ch_term[c]` sets status bit 3. The strobe also sets pending bit c (word at 0x1004) only when `ch_term_ie[c]` is high in the same cycle.
- R4: A halt strobe sets status bit 2 and control bit 3. An address-fault strobe sets status bit 4 and control bit 2. Either strobe sets pending bit c and clears the channel enable.
- R5: A status write can only clear the flag bits 2, 3 and 4: each flag keeps its value where the written bit is 1 and clears where it is 0. Writing 0 therefore clears all flags and stops the channel.
- R6: A write to the pending word keeps only the pending bits whose written bit is 1, so writing 0 clears all of them.
- R7: A channel event that arrives in the same cycle as a clearing write to its status or pending word wins, and the flag or pending bit stays set.
- R8: `irq_o` is high exactly when control bit 0 is set and at least one pending bit is set.
- R9: Control word at 0x1000: bit 0 (enable) and bit 31 (performance mode, driven on `perf_o`) take the written value. Bits 2 and 3 can only be cleared by writing 0 to them.
- R10: Writing a value to the doorbell at 0x100C drives `fetch_o` to that value's low channel bits for exactly one cycle. The doorbell reads as zero.
- R11: Channel c's descriptor address at c*0x20+0x18 is read/write and drives `desc_addr_o[c*32 +: 32]`.
- R12: The programmable-channel mask at 0x101C is read/write, one bit per channel, and drives `prog_o`.
- R13: Every other address reads zero and ignores writes. This covers addresses not aligned to four bytes, channel indices at or above the channel count, and unused offsets.
- R14: `bus_rdata` changes only one clock after a cycle with `bus_rd` high. It shows the register contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ch_term | input | NUM_CH | Per-channel transfer-complete strobe |
| ch_term_ie | input | NUM_CH | Interrupt wanted for the completion in the same cycle |
| ch_halt | input | NUM_CH | Per-channel halt strobe |
| ch_aerr | input | NUM_CH | Per-channel address-fault strobe |
| ch_en_o | output | NUM_CH | Channel enable bits |
| ch_desc8_o | output | NUM_CH | Eight-word descriptor select bits |
| fetch_o | output | NUM_CH | One-cycle descriptor fetch pulses |
| desc_addr_o | output | NUM_CH*32 | Descriptor base addresses, channel c at bits c*32 upward |
| prog_o | output | NUM_CH | Programmable-channel mask |
| perf_o | output | 1 | Performance-mode bit |
| irq_o | output | 1 | Combined interrupt |

## Verification
Directed sequences come first. Completions are tried with and without the interrupt qualifier, which separates the sticky status flag from pending-bit creation. Halts and faults are tried on enabled channels, which shows whether the event stops the channel and reaches the summary bits. Clearing writes of all-zero, all-ones and partial masks show clear-only behaviour apart from plain overwrite. An event is also applied in the same cycle as a clearing write, which exposes a wrong priority. After that, a long run of random strobes mixed with random writes to mapped and unmapped addresses is checked on every clock against a behavioural model. This catches cross-channel decode errors and mistakes in read timing.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 13'h1000;
  localparam logic [ADDR_W-1:0] A_PEND = 13'h1004;
  localparam logic [ADDR_W-1:0] A_BELL = 13'h100C;
  localparam logic [ADDR_W-1:0] A_PROG = 13'h101C;

  localparam int STRIDE_LSB = 5;
  localparam logic [STRIDE_LSB-1:0] O_STAT = 5'h10;
  localparam logic [STRIDE_LSB-1:0] O_DESC = 5'h18;

  // status word bit positions
  localparam int SB_EN = 0, SB_HALT = 2, SB_TERM = 3, SB_AERR = 4, SB_D8 = 30;
  // control word bit positions
  localparam int CB_EN = 0, CB_AERR = 2, CB_HALT = 3, CB_PERF = 31;

  typedef struct packed {
    logic d8;
    logic aerr;
    logic term;
    logic halt;
    logic en;
  } chan_st_t;

  function automatic logic [DATA_W-1:0] pack_status(chan_st_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SB_EN]   = s.en;
    w[SB_HALT] = s.halt;
    w[SB_TERM] = s.term;
    w[SB_AERR] = s.aerr;
    w[SB_D8]   = s.d8;
    return w;
  endfunction
endpackage

// File: rtl/dmairq_chan.sv
module dmairq_chan
  import dmairq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  logic              da_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_term,
  input  logic              ev_ie,
  input  logic              ev_halt,
  input  logic              ev_aerr,
  output chan_st_t          st_q,
  output logic [DATA_W-1:0] da_q,
  output logic              pend_set
);
  chan_st_t st_n;
  logic     stop;

  assign stop     = ev_halt | ev_aerr;
  assign pend_set = stop | (ev_term & ev_ie);

  always_comb begin
    st_n = st_q;
    if (st_we) begin
      st_n.en   = wdata[SB_EN];
      st_n.d8   = wdata[SB_D8];
      st_n.halt = st_q.halt & wdata[SB_HALT];
      st_n.term = st_q.term & wdata[SB_TERM];
      st_n.aerr = st_q.aerr & wdata[SB_AERR];
    end
    // events override a same-cycle write
    if (stop) st_n.en = 1'b0;
    st_n.halt = st_n.halt | ev_halt;
    st_n.term = st_n.term | ev_term;
    st_n.aerr = st_n.aerr | ev_aerr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      da_q <= '0;
    end else begin
      st_q <= st_n;
      if (da_we) da_q <= wdata;
    end
  end
endmodule

// File: rtl/dmairq_global.sv
module dmairq_global
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              pend_we,
  input  logic              bell_we,
  input  logic              prog_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] pend_set,
  input  logic              any_halt,
  input  logic              any_aerr,
  output logic              gen_q,
  output logic              perf_q,
  output logic              gaerr_q,
  output logic              ghalt_q,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] prog_q,
  output logic [NUM_CH-1:0] fetch_q
);
  logic [NUM_CH-1:0] pend_keep;
  logic              gaerr_keep, ghalt_keep;

  assign pend_keep  = pend_we ? (pend_q & wdata[NUM_CH-1:0]) : pend_q;
  assign gaerr_keep = ctrl_we ? (gaerr_q & wdata[CB_AERR]) : gaerr_q;
  assign ghalt_keep = ctrl_we ? (ghalt_q & wdata[CB_HALT]) : ghalt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      perf_q  <= 1'b0;
      gaerr_q <= 1'b0;
      ghalt_q <= 1'b0;
      pend_q  <= '0;
      prog_q  <= '0;
      fetch_q <= '0;
    end else begin
      if (ctrl_we) begin
        gen_q  <= wdata[CB_EN];
        perf_q <= wdata[CB_PERF];
      end
      gaerr_q <= gaerr_keep | any_aerr;
      ghalt_q <= ghalt_keep | any_halt;
      pend_q  <= pend_keep | pend_set;
      if (prog_we) prog_q <= wdata[NUM_CH-1:0];
      fetch_q <= bell_we ? wdata[NUM_CH-1:0] : '0;
    end
  end
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]        ch_term,
  input  logic [NUM_CH-1:0]        ch_term_ie,
  input  logic [NUM_CH-1:0]        ch_halt,
  input  logic [NUM_CH-1:0]        ch_aerr,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic [NUM_CH-1:0]        ch_desc8_o,
  output logic [NUM_CH-1:0]        fetch_o,
  output logic [NUM_CH*DATA_W-1:0] desc_addr_o,
  output logic [NUM_CH-1:0]        prog_o,
  output logic                     perf_o,
  output logic                     irq_o
);
  localparam int IDX_W = ADDR_W - 1 - STRIDE_LSB;

  logic [IDX_W-1:0]      idx;
  logic                  ch_hit, st_sel, da_sel;
  chan_st_t              st_a [NUM_CH];
  logic [DATA_W-1:0]     da_a [NUM_CH];
  logic [NUM_CH-1:0]     pend_set, pend_q;
  logic                  gen_q, gaerr_q, ghalt_q;
  logic [DATA_W-1:0]     rd_nxt;

  assign idx    = bus_addr[ADDR_W-2:STRIDE_LSB];
  assign ch_hit = !bus_addr[ADDR_W-1] && (bus_addr[1:0] == 2'b00) && (int'(idx) < NUM_CH);
  assign st_sel = ch_hit && (bus_addr[STRIDE_LSB-1:0] == O_STAT);
  assign da_sel = ch_hit && (bus_addr[STRIDE_LSB-1:0] == O_DESC);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = (idx == IDX_W'(g));
    dmairq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_we    (bus_wr && st_sel && sel),
      .da_we    (bus_wr && da_sel && sel),
      .wdata    (bus_wdata),
      .ev_term  (ch_term[g]),
      .ev_ie    (ch_term_ie[g]),
      .ev_halt  (ch_halt[g]),
      .ev_aerr  (ch_aerr[g]),
      .st_q     (st_a[g]),
      .da_q     (da_a[g]),
      .pend_set (pend_set[g])
    );
    assign ch_en_o[g]                      = st_a[g].en;
    assign ch_desc8_o[g]                   = st_a[g].d8;
    assign desc_addr_o[g*DATA_W +: DATA_W] = da_a[g];
  end

  dmairq_global #(.NUM_CH(NUM_CH)) u_glb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (bus_wr && bus_addr == A_CTRL),
    .pend_we  (bus_wr && bus_addr == A_PEND),
    .bell_we  (bus_wr && bus_addr == A_BELL),
    .prog_we  (bus_wr && bus_addr == A_PROG),
    .wdata    (bus_wdata),
    .pend_set (pend_set),
    .any_halt (|ch_halt),
    .any_aerr (|ch_aerr),
    .gen_q    (gen_q),
    .perf_q   (perf_o),
    .gaerr_q  (gaerr_q),
    .ghalt_q  (ghalt_q),
    .pend_q   (pend_q),
    .prog_q   (prog_o),
    .fetch_q  (fetch_o)
  );

  assign irq_o = gen_q && (|pend_q);

  always_comb begin
    rd_nxt = '0;
    unique case (bus_addr)
      A_CTRL: begin
        rd_nxt[CB_EN]   = gen_q;
        rd_nxt[CB_AERR] = gaerr_q;
        rd_nxt[CB_HALT] = ghalt_q;
        rd_nxt[CB_PERF] = perf_o;
      end
      A_PEND:  rd_nxt[NUM_CH-1:0] = pend_q;
      A_PROG:  rd_nxt[NUM_CH-1:0] = prog_o;
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == IDX_W'(c)) begin
        if (st_sel) rd_nxt = pack_status(st_a[c]);
        if (da_sel) rd_nxt = da_a[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] ch_term,
  input logic [NUM_CH-1:0] ch_term_ie,
  input logic [NUM_CH-1:0] ch_halt,
  input logic [NUM_CH-1:0] ch_aerr,
  input logic [NUM_CH-1:0] ch_en_o,
  input logic [NUM_CH-1:0] fetch_o,
  input logic [NUM_CH-1:0] pend_q,
  input logic              irq_o
);
  logic [NUM_CH-1:0] ev_pend;
  assign ev_pend = ch_halt | ch_aerr | (ch_term & ch_term_ie);

  assert_fetch_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_o != '0) |-> $past(bus_wr && bus_addr == A_BELL));

  assert_stop_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_halt | ch_aerr) != '0) |=> ((ch_en_o & $past(ch_halt | ch_aerr)) == '0));

  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pend != '0) |=> ((pend_q & $past(ev_pend)) == $past(ev_pend)));

  assert_irq_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PEND && bus_wdata == '0 && ev_pend == '0) |=> !irq_o);

  assert_misaligned_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

  assert_rdata_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind dmairq_regs dmairq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ch_term    (ch_term),
  .ch_term_ie (ch_term_ie),
  .ch_halt    (ch_halt),
  .ch_aerr    (ch_aerr),
  .ch_en_o    (ch_en_o),
  .fetch_o    (fetch_o),
  .pend_q     (pend_q),
  .irq_o      (irq_o)
);

// File: tb/tb_dmairq_regs.sv
`timescale 1ns/1ps
module tb_dmairq_regs;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] ch_term = '0, ch_term_ie = '0, ch_halt = '0, ch_aerr = '0;
  logic [N-1:0] ch_en_o, ch_desc8_o, fetch_o, prog_o;
  logic [N*32-1:0] desc_addr_o;
  logic perf_o, irq_o;

  always #2.5 clk = ~clk;

  dmairq_regs #(.NUM_CH(N)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit [31:0] m_en, m_d8, m_h, m_t, m_a, m_pend, m_prog, m_fetch, m_rdata;
  bit [31:0] m_da [N];
  bit m_gen, m_perf, m_gaerr, m_ghalt;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] mread(input bit [12:0] a);
    int ch = a >> 5;
    int off = a & 31;
    if (a == 13'h1000) return {m_perf, 27'b0, m_ghalt, m_gaerr, 1'b0, m_gen};
    if (a == 13'h1004) return m_pend;
    if (a == 13'h101C) return m_prog;
    if (a < 13'h1000 && (a & 3) == 0 && ch < N) begin
      if (off == 16) return {1'b0, m_d8[ch], 25'b0, m_a[ch], m_t[ch], m_h[ch], 1'b0, m_en[ch]};
      if (off == 24) return m_da[ch];
    end
    return 0;
  endfunction

  task automatic compare_all();
    chk(irq_o, (m_gen && m_pend != 0), "R8 irq_o");
    chk(fetch_o, m_fetch, "R10 fetch_o");
    chk(ch_en_o, m_en, "R2 ch_en_o");
    chk(ch_desc8_o, m_d8, "R2 ch_desc8_o");
    chk(prog_o, m_prog, "R12 prog_o");
    chk(perf_o, m_perf, "R9 perf_o");
    chk(bus_rdata, m_rdata, "R14 bus_rdata");
    for (int c = 0; c < N; c++) chk(desc_addr_o[c*32 +: 32], m_da[c], "R11 desc_addr_o");
  endtask

  task automatic step(input bit wr, input bit rd, input bit [12:0] a, input bit [31:0] wd,
                      input bit [31:0] tm, input bit [31:0] ie, input bit [31:0] hl, input bit [31:0] ae);
    int ch;
    bit st_w, pend_w, ctrl_w;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    ch_term = tm; ch_term_ie = ie; ch_halt = hl; ch_aerr = ae;
    if (rd) m_rdata = mread(a);
    ch = a >> 5;
    st_w = wr && a < 13'h1000 && (a & 3) == 0 && ch < N && (a & 31) == 16;
    for (int c = 0; c < N; c++) begin
      if (st_w && c == ch) begin
        m_en[c] = wd[0]; m_d8[c] = wd[30];
        m_h[c] = m_h[c] & wd[2]; m_t[c] = m_t[c] & wd[3]; m_a[c] = m_a[c] & wd[4];
      end
      if (hl[c] || ae[c]) m_en[c] = 0;
      m_h[c] = m_h[c] | hl[c]; m_t[c] = m_t[c] | tm[c]; m_a[c] = m_a[c] | ae[c];
      if (wr && a < 13'h1000 && (a & 3) == 0 && ch < N && (a & 31) == 24 && c == ch) m_da[c] = wd;
    end
    pend_w = wr && a == 13'h1004;
    ctrl_w = wr && a == 13'h1000;
    if (pend_w) m_pend = m_pend & wd;
    m_pend = m_pend | hl | ae | (tm & ie);
    if (ctrl_w) begin
      m_gen = wd[0]; m_perf = wd[31];
      m_gaerr = m_gaerr & wd[2]; m_ghalt = m_ghalt & wd[3];
    end
    m_gaerr = m_gaerr | (ae != 0);
    m_ghalt = m_ghalt | (hl != 0);
    if (wr && a == 13'h101C) m_prog = wd;
    m_fetch = (wr && a == 13'h100C) ? wd : 0;
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic wr_reg(input bit [12:0] a, input bit [31:0] d);
    step(1, 0, a, d, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(input bit [12:0] a);
    step(0, 1, a, 0, 0, 0, 0, 0);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(irq_o, 0, "R1 irq after reset");
    chk(bus_rdata, 0, "R1 rdata after reset");
    compare_all();
    rd_reg(13'h1000); chk(bus_rdata, 0, "R1 ctrl reset");
    rd_reg(13'h0010); chk(bus_rdata, 0, "R1 status reset");

    wr_reg(13'h00B0, 32'h4000_0001);
    chk(ch_en_o[5], 1, "R2 enable bit");
    chk(ch_desc8_o[5], 1, "R2 desc8 bit");
    rd_reg(13'h00B0); chk(bus_rdata, 32'h4000_0001, "R2 status readback");

    step(0, 0, 0, 0, 32'h20, 32'h20, 0, 0);
    rd_reg(13'h00B0); chk(bus_rdata, 32'h4000_0009, "R3 term flag");
    rd_reg(13'h1004); chk(bus_rdata, 32'h20, "R3 pending with ie");
    chk(irq_o, 0, "R8 gated by enable");
    wr_reg(13'h1000, 32'h8000_0001);
    chk(irq_o, 1, "R8 irq raised");
    chk(perf_o, 1, "R9 perf bit");

    step(0, 0, 0, 0, 32'h80, 0, 0, 0);
    rd_reg(13'h00F0); chk(bus_rdata, 32'h8, "R3 term flag without ie");
    rd_reg(13'h1004); chk(bus_rdata, 32'h20, "R3 no pending without ie");

    wr_reg(13'h0050, 32'h1);
    step(0, 0, 0, 0, 0, 0, 32'h4, 0);
    chk(ch_en_o[2], 0, "R4 halt stops channel");
    rd_reg(13'h0050); chk(bus_rdata, 32'h4, "R4 halt flag");
    rd_reg(13'h1000); chk(bus_rdata, 32'h8000_0009, "R4 global halt");
    step(0, 0, 0, 0, 0, 0, 0, 32'h8000_0000);
    rd_reg(13'h03F0); chk(bus_rdata, 32'h10, "R4 aerr flag");
    rd_reg(13'h1000); chk(bus_rdata, 32'h8000_000D, "R4 global aerr");
    rd_reg(13'h1004); chk(bus_rdata, 32'h8000_0024, "R4 pending bits");

    wr_reg(13'h00B0, 32'h0000_001C);
    rd_reg(13'h00B0); chk(bus_rdata, 32'h8, "R5 ones keep flags");
    wr_reg(13'h00B0, 32'h0);
    rd_reg(13'h00B0); chk(bus_rdata, 32'h0, "R5 zero clears");

    wr_reg(13'h1004, 32'hFFFF_FFDF);
    rd_reg(13'h1004); chk(bus_rdata, 32'h8000_0004, "R6 partial clear");
    step(1, 0, 13'h1004, 0, 0, 0, 32'h200, 0);
    rd_reg(13'h1004); chk(bus_rdata, 32'h200, "R7 event beats pending clear");
    chk(irq_o, 1, "R8 irq held by collision");
    wr_reg(13'h1004, 0);
    chk(irq_o, 0, "R6 irq drops after zero write");
    step(1, 0, 13'h0130, 0, 0, 0, 0, 32'h200);
    rd_reg(13'h0130); chk(bus_rdata, 32'h10, "R7 event beats status clear");

    wr_reg(13'h1000, 32'h0000_000D);
    rd_reg(13'h1000); chk(bus_rdata, 32'h0000_000D, "R9 flags kept by ones");
    wr_reg(13'h1000, 32'h1);
    rd_reg(13'h1000); chk(bus_rdata, 32'h1, "R9 flags cleared by zeros");

    wr_reg(13'h100C, 32'h105);
    chk(fetch_o, 32'h105, "R10 fetch pulse");
    idle(); chk(fetch_o, 0, "R10 pulse one cycle");
    rd_reg(13'h100C); chk(bus_rdata, 0, "R10 doorbell reads zero");

    wr_reg(13'h0078, 32'hDEAD_BEE0);
    chk(desc_addr_o[3*32 +: 32], 32'hDEAD_BEE0, "R11 desc output");
    rd_reg(13'h0078); chk(bus_rdata, 32'hDEAD_BEE0, "R11 desc readback");
    idle(); chk(bus_rdata, 32'hDEAD_BEE0, "R14 rdata held");

    wr_reg(13'h101C, 32'h0000_F00F);
    chk(prog_o, 32'h0000_F00F, "R12 prog output");
    rd_reg(13'h101C); chk(bus_rdata, 32'h0000_F00F, "R12 prog readback");

    wr_reg(13'h1008, 32'hFFFF_FFFF);
    rd_reg(13'h1008); chk(bus_rdata, 0, "R13 unmapped global");
    wr_reg(13'h00B2, 32'h1);
    chk(ch_en_o[5], 0, "R13 misaligned write ignored");
    rd_reg(13'h00B2); chk(bus_rdata, 0, "R13 misaligned read");
    rd_reg(13'h0000); chk(bus_rdata, 0, "R13 unused channel offset");
    wr_reg(13'h1FFC, 32'hFFFF_FFFF);
    rd_reg(13'h1FFC); chk(bus_rdata, 0, "R13 top of space");

    for (int i = 0; i < 3000; i++) begin
      bit [12:0] a;
      bit [31:0] d;
      int k = $urandom_range(0, 9);
      int c = $urandom_range(0, N - 1);
      case (k)
        0: a = 13'h1000;
        1: a = 13'h1004;
        2: a = 13'h100C;
        3: a = 13'h101C;
        4, 5: a = 13'(c * 32 + 16);
        6: a = 13'(c * 32 + 24);
        default: a = 13'($urandom);
      endcase
      d = $urandom;
      if (k == 1) d = d | $urandom;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, a, d,
           $urandom & $urandom & $urandom, $urandom,
           $urandom & $urandom & $urandom & $urandom,
           $urandom & $urandom & $urandom & $urandom);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule